// File: doc/BRIEF.md
# Event Timer Register and Counter

This block is the register front end of a three-channel event timer. It owns a 64-bit main counter that steps by one on every cycle where the tick strobe is high and the global enable is set. It also decodes a 1 KiB window of 32-bit registers. The window holds a fixed capability word and the tick period, the global configuration word, an interrupt status word and the two halves of the main counter. The rest of the window is a bank of per-channel registers, which the block passes on to the comparator channels.

Software turns the timer on and off through the global enable bit. While the enable is clear the counter holds its value, and when the enable is set again counting resumes from that value. Each change of the enable bit produces one-cycle pulses that tell the channels to re-arm or to disarm. The legacy-route bit is brought out as a pin so that neighbouring legacy timers can silence their own interrupts. Comparator matching and interrupt generation sit in the channel blocks, not here.

The request port always accepts a request. A write takes effect at the clock edge where it is presented. A read returns its data on the response port one cycle later, and the value returned is the one sampled in the request cycle.

Top module: `evt_timer_regs`

## Requirements
- R1: After synchronous reset the following are all zero: the counter, the enable bit, the legacy bit, the arm and disarm pulses, and rsp_valid.
- R2: A read of offset 0x000 returns 0x80868201. A read of offset 0x004 returns the tick period, 0x00989680 (10,000,000 fs). A write to either offset is ignored.
- R3: In the configuration word at offset 0x010, only bit 0 (enable) and bit 1 (legacy route) are writable; a read returns {30'b0, legacy, enable}. A read of offset 0x014 returns 0. main_enable and legacy_route reflect the two bits from the cycle after the write.
- R4: While the enable is set, the counter adds 1 in each cycle where tick is high. While the enable is clear, the counter holds its value. Setting the enable again resumes counting from the held value.
- R5: A write to 0x0F0 replaces count bits 31:0 and a write to 0x0F4 replaces bits 63:32. A counter write wins over a tick in the same cycle, including while enabled. A read of 0x0F0 returns count bits 31:0. A read of 0x0F4 returns 0.
- R6: A read of the status word at 0x020 returns 0, and writes to it are ignored.
- R7: A write that changes the enable from 0 to 1 pulses arm[i] for one cycle, in the cycle after the write, for each channel i whose cmp_all_ones[i] is 0. A write that changes it from 1 to 0 pulses disarm on all three channels for one cycle. A configuration write that leaves the enable unchanged produces no pulse.
- R8: Offsets 0x100 and above are decoded as channel k = (offset-0x100)/0x20, with word index (offset bits 4:2). For k below 3, ch_wr or ch_rd strobes in the request cycle, with ch_idx = k, and a read returns ch_rdata. For k of 3 or more, no strobe is issued and a read returns 0.
- R9: A read of any other offset returns 0x0000000A, and a write to one is ignored.
- R10: req_ready is always 1. rsp_valid is high in exactly the cycle after each read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Register request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Byte offset in the register window |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Request accepted (always 1) |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| tick | input | 1 | Counter tick strobe |
| ch_rdata | input | 32 | Read data from the addressed channel, same cycle |
| cmp_all_ones | input | 3 | Per channel: comparator holds all ones |
| ch_wr | output | 1 | Channel register write strobe |
| ch_rd | output | 1 | Channel register read strobe |
| ch_idx | output | 2 | Addressed channel |
| ch_woff | output | 3 | Word index inside the channel stride |
| ch_wdata | output | 32 | Channel write data |
| arm | output | 3 | One-cycle re-arm pulse per channel |
| disarm | output | 3 | One-cycle disarm pulse per channel |
| legacy_route | output | 1 | Legacy-route bit |
| main_enable | output | 1 | Global enable bit |
| count | output | 64 | Main counter value |

## Verification
Two of the block's actions can meet in one clock cycle. The first is a tick, which would increment the counter. The second is a software write to either counter half, or a configuration write that flips the enable bit. The bench holds tick high while it writes to 0x0F0 and 0x0F4 with the timer running, and while it toggles the enable. A behavioural model updates once per clock, lets the written value win over the increment, and applies the old enable to the tick in the write cycle. It compares the count, the read data and the arm and disarm pulses against the RTL after every edge. A long run of seeded random accesses, with tick toggling underneath, produces further collisions of this kind.

// File: rtl/evt_timer_pkg.sv
// Package: shared constants and the register region type of the event
// timer register block. Assumes a 1 KiB byte-addressed window of 32-bit words.
package evt_timer_pkg;
    localparam logic [31:0] CAP_LO_WORD  = 32'h8086_8201;
    localparam logic [31:0] TICK_FS      = 32'd10_000_000;
    localparam logic [31:0] UNDEC_RDATA  = 32'h0000_000A;

    typedef enum logic [3:0] {
        RG_CAP, RG_PERIOD, RG_CFG, RG_CFG_HI, RG_STAT,
        RG_CNT_LO, RG_CNT_HI, RG_CHAN, RG_CHAN_OOR, RG_NONE
    } reg_region_e;
endpackage

// File: rtl/etr_decode.sv
// Module: combinational address decoder. Sorts a byte offset into a
// register region and, for the channel window, works out the channel number
// and the word index. Assumes word-aligned offsets; bits 1:0 are ignored.
module etr_decode
    import evt_timer_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int N_CH        = 3,
    parameter int STRIDE_LOG2 = 5,
    parameter int CH_BASE     = 'h100,
    localparam int CH_IDX_W   = (N_CH > 1) ? $clog2(N_CH) : 1,
    localparam int WOFF_W     = STRIDE_LOG2 - 2,
    localparam int REL_W      = ADDR_W - STRIDE_LOG2
) (
    input  logic [ADDR_W-1:0]   addr,
    output reg_region_e         region,
    output logic [CH_IDX_W-1:0] ch_idx,
    output logic [WOFF_W-1:0]   ch_woff
);
    logic [ADDR_W-1:0] word_addr;
    logic [ADDR_W-1:0] rel;
    logic [REL_W-1:0]  rel_idx;

    assign word_addr = {addr[ADDR_W-1:2], 2'b00};
    assign rel       = word_addr - ADDR_W'(CH_BASE);
    assign rel_idx   = rel[ADDR_W-1:STRIDE_LOG2];
    assign ch_idx    = rel_idx[CH_IDX_W-1:0];
    assign ch_woff   = addr[STRIDE_LOG2-1:2];

    // Purpose: classify the offset into one region.
    always_comb begin
        if (word_addr >= ADDR_W'(CH_BASE)) begin
            region = (rel_idx < REL_W'(N_CH)) ? RG_CHAN : RG_CHAN_OOR;
        end else begin
            case (word_addr)
                ADDR_W'('h000): region = RG_CAP;
                ADDR_W'('h004): region = RG_PERIOD;
                ADDR_W'('h010): region = RG_CFG;
                ADDR_W'('h014): region = RG_CFG_HI;
                ADDR_W'('h020): region = RG_STAT;
                ADDR_W'('h0F0): region = RG_CNT_LO;
                ADDR_W'('h0F4): region = RG_CNT_HI;
                default:        region = RG_NONE;
            endcase
        end
    end
endmodule

// File: rtl/etr_counter.sv
// Module: main counter. Steps by one on a tick while running and holds
// otherwise. A write to either half wins over the step in the same cycle.
// Assumes CNT_W is twice HALF_W.
module etr_counter #(
    parameter int CNT_W  = 64,
    parameter int HALF_W = 32,
    localparam int HI_W  = CNT_W - HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [HALF_W-1:0] wdata,
    output logic [CNT_W-1:0]  count
);
    // Purpose: counter register with write priority over increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (wr_lo) begin
            count[HALF_W-1:0] <= wdata;
        end else if (wr_hi) begin
            count[CNT_W-1:HALF_W] <= wdata[HI_W-1:0];
        end else if (run && tick) begin
            count <= count + 1'b1;
        end
    end

    // R4: holds when stopped and not written
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_lo && !wr_hi) |=> $stable(count));

    // R4: steps by exactly one when running, ticking and not written
    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !wr_lo && !wr_hi) |=> (count == $past(count) + 1'b1));

    // R5: a low-half write lands even while ticking
    p_wr_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> (count[HALF_W-1:0] == $past(wdata)));
endmodule

// File: rtl/etr_gcfg.sv
// Module: global configuration bits (enable, legacy route) and the
// per-channel re-arm / disarm pulses created on enable edges. Assumes one
// write strobe per cycle carrying the two writable bits.
module etr_gcfg #(
    parameter int N_CH = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic [1:0]      wbits,
    input  logic [N_CH-1:0] cmp_all_ones,
    output logic            en,
    output logic            legacy,
    output logic [N_CH-1:0] arm,
    output logic [N_CH-1:0] disarm
);
    logic rise, fall;
    assign rise = wr && !en && wbits[0];
    assign fall = wr && en && !wbits[0];

    // Purpose: hold the two writable configuration bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en     <= 1'b0;
            legacy <= 1'b0;
        end else if (wr) begin
            en     <= wbits[0];
            legacy <= wbits[1];
        end
    end

    // Purpose: one pulse generator per channel.
    for (genvar i = 0; i < N_CH; i++) begin : g_pulse
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                arm[i]    <= 1'b0;
                disarm[i] <= 1'b0;
            end else begin
                arm[i]    <= rise && !cmp_all_ones[i];
                disarm[i] <= fall;
            end
        end
    end

    // R7: re-arm only right after the enable rose
    p_arm_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|arm) |-> (en && !$past(en)));

    // R7: disarm only right after the enable fell
    p_disarm_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|disarm) |-> (!en && $past(en)));

    // R7: pulses last one cycle
    p_arm_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|arm) |=> (arm == '0));
endmodule

// File: rtl/evt_timer_regs.sv
// Module: top of the event timer register block. Decodes single-word
// requests, keeps the counter and the global configuration, forwards the
// channel window and returns read data one cycle later. Assumes the channel
// answers ch_rdata in the same cycle as ch_rd.
module evt_timer_regs
    import evt_timer_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int DATA_W      = 32,
    parameter int N_CH        = 3,
    parameter int CNT_W       = 64,
    parameter int STRIDE_LOG2 = 5,
    parameter int CH_BASE     = 'h100,
    localparam int CH_IDX_W   = (N_CH > 1) ? $clog2(N_CH) : 1,
    localparam int WOFF_W     = STRIDE_LOG2 - 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic                req_ready,
    output logic                rsp_valid,
    output logic [DATA_W-1:0]   rsp_rdata,
    input  logic                tick,
    input  logic [DATA_W-1:0]   ch_rdata,
    input  logic [N_CH-1:0]     cmp_all_ones,
    output logic                ch_wr,
    output logic                ch_rd,
    output logic [CH_IDX_W-1:0] ch_idx,
    output logic [WOFF_W-1:0]   ch_woff,
    output logic [DATA_W-1:0]   ch_wdata,
    output logic [N_CH-1:0]     arm,
    output logic [N_CH-1:0]     disarm,
    output logic                legacy_route,
    output logic                main_enable,
    output logic [CNT_W-1:0]    count
);
    reg_region_e       region;
    logic              do_wr, do_rd;
    logic [DATA_W-1:0] rd_mux;

    assign req_ready = 1'b1;
    assign do_wr     = req_valid && req_write;
    assign do_rd     = req_valid && !req_write;

    etr_decode #(
        .ADDR_W(ADDR_W), .N_CH(N_CH), .STRIDE_LOG2(STRIDE_LOG2), .CH_BASE(CH_BASE)
    ) u_dec (
        .addr(req_addr), .region(region), .ch_idx(ch_idx), .ch_woff(ch_woff)
    );

    etr_counter #(.CNT_W(CNT_W), .HALF_W(DATA_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(main_enable), .tick(tick),
        .wr_lo(do_wr && region == RG_CNT_LO),
        .wr_hi(do_wr && region == RG_CNT_HI),
        .wdata(req_wdata), .count(count)
    );

    etr_gcfg #(.N_CH(N_CH)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .wr(do_wr && region == RG_CFG), .wbits(req_wdata[1:0]),
        .cmp_all_ones(cmp_all_ones),
        .en(main_enable), .legacy(legacy_route),
        .arm(arm), .disarm(disarm)
    );

    assign ch_wr    = do_wr && region == RG_CHAN;
    assign ch_rd    = do_rd && region == RG_CHAN;
    assign ch_wdata = req_wdata;

    // Purpose: select the read value of the addressed register.
    always_comb begin
        case (region)
            RG_CAP:    rd_mux = CAP_LO_WORD;
            RG_PERIOD: rd_mux = TICK_FS;
            RG_CFG:    rd_mux = {{(DATA_W-2){1'b0}}, legacy_route, main_enable};
            RG_CNT_LO: rd_mux = count[DATA_W-1:0];
            RG_CHAN:   rd_mux = ch_rdata;
            RG_NONE:   rd_mux = UNDEC_RDATA;
            default:   rd_mux = '0;
        endcase
    end

    // Purpose: one-cycle read response register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= do_rd;
            if (do_rd) rsp_rdata <= rd_mux;
        end
    end

    // R10: every read is answered in the next cycle
    p_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        do_rd |=> rsp_valid);

    // R10: no response without a read
    p_no_spur_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !do_rd |=> !rsp_valid);

    // R8: a channel strobe is either read or write, never both
    p_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({ch_wr, ch_rd}) <= 1);

    // R3: the enable only changes on a configuration write
    p_en_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(do_wr && region == RG_CFG) |=> $stable(main_enable));
endmodule

// File: tb/sim_evt_timer_regs.sv
module sim_evt_timer_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [9:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        tick = 1'b0;
    logic [2:0]  cmp_all_ones = '0;
    logic [31:0] ch_rdata;
    logic        req_ready, rsp_valid, ch_wr, ch_rd, legacy_route, main_enable;
    logic [31:0] rsp_rdata, ch_wdata;
    logic [1:0]  ch_idx;
    logic [2:0]  ch_woff, arm, disarm;
    logic [63:0] count;

    always #2 clk = ~clk;

    // channel stub: data encodes the addressed channel and word
    assign ch_rdata = 32'hC0DE_0000 | {22'd0, ch_idx, 5'd0, ch_woff};

    evt_timer_regs u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .tick(tick),
        .ch_rdata(ch_rdata), .cmp_all_ones(cmp_all_ones), .ch_wr(ch_wr),
        .ch_rd(ch_rd), .ch_idx(ch_idx), .ch_woff(ch_woff), .ch_wdata(ch_wdata),
        .arm(arm), .disarm(disarm), .legacy_route(legacy_route),
        .main_enable(main_enable), .count(count)
    );

    int nchk = 0, nerr = 0;
    bit done = 0;

    // reference model state
    bit          m_en, m_leg, m_rv;
    logic [63:0] m_cnt;
    logic [31:0] m_rd;
    logic [2:0]  m_arm, m_dis;
    string       m_tag;

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int chan_of(input logic [9:0] a);
        return (int'({a[9:2], 2'b00}) - 'h100) / 'h20;
    endfunction

    function automatic string tag_of(input logic [9:0] a);
        int w = int'({a[9:2], 2'b00});
        if (w >= 'h100) return "R8";
        case (w)
            'h000, 'h004: return "R2";
            'h010, 'h014: return "R3";
            'h020:        return "R6";
            'h0F0, 'h0F4: return "R5";
            default:      return "R9";
        endcase
    endfunction

    function automatic logic [31:0] model_read(input logic [9:0] a);
        int w = int'({a[9:2], 2'b00});
        if (w >= 'h100) begin
            int k = chan_of(a);
            if (k < 3) return 32'hC0DE_0000 | (k << 8) | int'(a[4:2]);
            return 32'h0;
        end
        case (w)
            'h000:   return 32'h8086_8201;
            'h004:   return 32'h0098_9680;
            'h010:   return {30'd0, m_leg, m_en};
            'h014:   return 32'h0;
            'h020:   return 32'h0;
            'h0F0:   return m_cnt[31:0];
            'h0F4:   return 32'h0;
            default: return 32'h0000_000A;
        endcase
    endfunction

    // one clock: check strobes, then the edge, then the registered outputs
    task automatic cyc();
        bit chan_hit;
        int w;
        #1;
        chan_hit = req_valid && ({req_addr[9:2], 2'b00} >= 10'h100) && chan_of(req_addr) < 3;
        chk("R8", "ch_wr", ch_wr, chan_hit && req_write);
        chk("R8", "ch_rd", ch_rd, chan_hit && !req_write);
        if (chan_hit) begin
            chk("R8", "ch_idx", ch_idx, chan_of(req_addr));
            chk("R8", "ch_woff", ch_woff, req_addr[4:2]);
        end
        chk("R10", "req_ready", req_ready, 1'b1);
        @(posedge clk);
        w = int'({req_addr[9:2], 2'b00});
        if (!rst_n) begin
            m_en = 0; m_leg = 0; m_cnt = 0; m_rv = 0; m_rd = 0; m_arm = 0; m_dis = 0;
        end else begin
            m_rv = req_valid && !req_write;
            if (m_rv) begin m_rd = model_read(req_addr); m_tag = tag_of(req_addr); end
            m_arm = 0; m_dis = 0;
            if (req_valid && req_write && w == 'h0F0)      m_cnt[31:0]  = req_wdata;
            else if (req_valid && req_write && w == 'h0F4) m_cnt[63:32] = req_wdata;
            else if (m_en && tick)                         m_cnt = m_cnt + 1;
            if (req_valid && req_write && w == 'h010) begin
                if (!m_en && req_wdata[0]) m_arm = ~cmp_all_ones;
                if (m_en && !req_wdata[0]) m_dis = 3'b111;
                m_en = req_wdata[0]; m_leg = req_wdata[1];
            end
        end
        #1;
        chk("R10", "rsp_valid", rsp_valid, m_rv);
        if (m_rv && rst_n) chk(m_tag, "rsp_rdata", rsp_rdata, m_rd);
        chk("R4", "count", count, m_cnt);
        chk("R3", "main_enable", main_enable, m_en);
        chk("R3", "legacy_route", legacy_route, m_leg);
        chk("R7", "arm", arm, m_arm);
        chk("R7", "disarm", disarm, m_dis);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin req_valid = 0; cyc(); end
    endtask

    task automatic rd(input logic [9:0] a);
        req_valid = 1; req_write = 0; req_addr = a; cyc(); req_valid = 0;
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d; cyc(); req_valid = 0;
    endtask

    initial begin : watchdog
        #800000;
        if (!done) begin
            nerr++; nchk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin : stim
        logic [9:0] pick [16];
        pick = '{10'h000, 10'h004, 10'h010, 10'h014, 10'h020, 10'h0F0, 10'h0F4, 10'h008,
                 10'h100, 10'h128, 10'h150, 10'h16C, 10'h160, 10'h3E0, 10'h0F8, 10'h010};
        @(negedge clk);
        for (int i = 0; i < 4; i++) cyc();
        rst_n = 1;
        // R1: reset state
        chk("R1", "count after reset", count, 64'd0);
        chk("R1", "enable after reset", main_enable, 1'b0);
        chk("R1", "arm after reset", arm, 3'b0);
        idle(1);
        // R2: constant words, writes ignored
        rd(10'h000); rd(10'h004); wr(10'h000, 32'h1234_5678); rd(10'h000);
        // R3: only two bits writable, upper word reads 0
        wr(10'h010, 32'hFFFF_FFFE); rd(10'h010); rd(10'h014);
        // R4 stopped: tick has no effect
        tick = 1; idle(3); rd(10'h0F0);
        // R7: enable rise with channel 1 comparator all ones
        cmp_all_ones = 3'b010;
        wr(10'h010, 32'h3);
        // R4: counting with a toggling tick
        for (int i = 0; i < 10; i++) begin tick = i[0]; idle(1); end
        tick = 1; rd(10'h0F0); rd(10'h010);
        // R7: same-enable write gives no pulse
        wr(10'h010, 32'h1);
        // R5: counter writes collide with ticks while enabled
        wr(10'h0F0, 32'hFFFF_FFFE); idle(3); wr(10'h0F4, 32'hA5A5_0001); rd(10'h0F4); rd(10'h0F0);
        // R7: disable -> disarm; R4 hold and resume
        wr(10'h010, 32'h0); idle(4); rd(10'h0F0);
        wr(10'h0F0, 32'h0000_0100); idle(2);
        cmp_all_ones = 3'b000; wr(10'h010, 32'h1); idle(5); rd(10'h0F0);
        // R6: status writes ignored
        wr(10'h020, 32'hFFFF_FFFF); rd(10'h020);
        // R8: channel window
        wr(10'h100, 32'h1111); wr(10'h148, 32'h2222); wr(10'h150, 32'h3333);
        rd(10'h10C); rd(10'h124); rd(10'h158); rd(10'h160); rd(10'h3FC); wr(10'h3E0, 32'h4444);
        // R9: undecoded offsets
        rd(10'h008); rd(10'h030); rd(10'h0F8); wr(10'h030, 32'h5); rd(10'h030);
        // seeded random mix
        for (int i = 0; i < 600; i++) begin
            int r = $urandom_range(0, 99);
            tick = ($urandom_range(0, 3) != 0);
            cmp_all_ones = 3'($urandom_range(0, 7));
            if (r < 30) rd(pick[$urandom_range(0, 15)]);
            else if (r < 50) wr(pick[$urandom_range(0, 15)], $urandom());
            else idle(1);
        end
        // R1: reset again mid-run
        rst_n = 0; idle(2); rst_n = 1; idle(1);
        chk("R1", "count after second reset", count, 64'd0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule